// File: doc/BRIEF.md
# Serial I/Q Sample Transmitter

This block takes parallel I/Q sample pairs from a baseband datapath and sends them as a bit-serial stream, one bit per clock, together with a framing strobe. A pair is taken over a valid/ready handshake. Its words and the framing configuration are captured together at that moment, so every sample can carry its own settings. Samples accepted back to back follow one another with no idle slot between them.

The framing is set by five configuration inputs:
- Lane use: two lanes, one for I and one for Q, or a single shared lane.
- Sample width: 16 bits, or 12 bits taken from the top of each word.
- Strobe style: a single-slot pulse, or a strobe that is high for the first half of the sample.
- Bit order: MSB first or LSB first.
- Word order on the single lane: I first or Q first.

When nothing is queued, all serial outputs rest low. Generating the bit clock and driving the differential pads belong to the surrounding logic.

Top module: `lvds_iq_serializer`

## Requirements
- R1: While reset is active, and whenever no sample is being sent, `lane_i_o`, `lane_q_o` and `strobe_o` are 0 and `in_ready_o` is 1. The reset is asynchronous.
- R2: `in_ready_o` is 1 only while idle or during the last bit slot of the sample being sent. A pair is accepted on a rising edge with `in_valid_i` and `in_ready_o` both high. The words and the configuration inputs are captured at that edge, and later changes to them do not affect the sample in flight.
- R3: The first bit and the strobe's rising edge appear in the slot that directly follows the accepting edge. A pair accepted in the last slot of the previous sample starts with no gap.
- R4: With `single_lane_i`=0, the I word goes out on `lane_i_o` and the Q word goes out on `lane_q_o` in the same N slots, where N is the sample width.
- R5: With `narrow_i`=1, N=12 and only bits [15:4] of each word are sent. With `narrow_i`=0, N=16 and bits [15:0] are sent.
- R6: With `lsb_first_i`=0, bit 15 goes first and the bits follow in descending order. With `lsb_first_i`=1, the lowest sent bit goes first (bit 4 when N=12, bit 0 when N=16) and the bits follow in ascending order.
- R7: With `single_lane_i`=1, a sample takes 2N slots on `lane_i_o`. The I word goes first when `q_first_i`=0 and the Q word goes first when `q_first_i`=1. `lane_q_o` stays 0 throughout.
- R8: With `long_strobe_i`=0, `strobe_o` is 1 in the first slot of each sample only.
- R9: With `long_strobe_i`=1 and two lanes, `strobe_o` is 1 in slots 0 to N/2-1 and 0 in the rest.
- R10: With `long_strobe_i`=1 and the single lane, `strobe_o` is 1 for all N slots of the first word and 0 for the second word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one serial bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| single_lane_i | input | 1 | 1: both words share `lane_i_o`; 0: separate lanes |
| narrow_i | input | 1 | 1: 12-bit samples; 0: 16-bit samples |
| long_strobe_i | input | 1 | 1: half-duration strobe; 0: single-slot strobe |
| lsb_first_i | input | 1 | 1: LSB first; 0: MSB first |
| q_first_i | input | 1 | Single lane only: 1 sends Q before I |
| in_valid_i | input | 1 | Sample pair offered |
| in_ready_o | output | 1 | Block can take a pair on this edge |
| i_word_i | input | 16 | I word |
| q_word_i | input | 16 | Q word |
| lane_i_o | output | 1 | Serial I lane, or the shared lane |
| lane_q_o | output | 1 | Serial Q lane |
| strobe_o | output | 1 | Sample framing strobe |

## Verification
The assertions check the following on every cycle:
- the strobe rises only in the slot after an accept, and every accept produces a strobe in the next slot;
- an idle handshake (ready high, valid low) is followed by quiet outputs;
- a short strobe never lasts two slots;
- the Q lane stays silent in single-lane mode.

Only the bench's scenarios can show that the bit order, the word order, the 12-bit truncation and the long-strobe length are correct slot by slot, because these depend on the captured data. The same holds for configuration changes in mid-sample having no effect and for an asynchronous reset cutting a sample short.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;
  typedef struct packed {
    logic single_lane;
    logic narrow;
    logic long_strobe;
    logic lsb_first;
    logic q_first;
  } ser_cfg_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import lvds_ser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  ser_cfg_t         cfg_i,
  output logic             ready_o,
  output logic             load_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] slot_o,
  output ser_cfg_t         cfg_o
);
  localparam logic [CNT_W:0] FULL_N = (CNT_W+1)'(WORD_W);
  localparam logic [CNT_W:0] SHORT_N = (CNT_W+1)'(NARROW_W);

  logic             busy_q;
  logic [CNT_W-1:0] slot_q;
  ser_cfg_t         cfg_q;
  logic [CNT_W:0]   base_n, last_slot;
  logic             at_last;

  always_comb begin
    base_n    = cfg_q.narrow ? SHORT_N : FULL_N;
    last_slot = (cfg_q.single_lane ? (base_n << 1) : base_n) - 1'b1;
    at_last   = busy_q && ({1'b0, slot_q} == last_slot);
  end

  assign ready_o = !busy_q || at_last;
  assign load_o  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      cfg_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      slot_q <= '0;
      cfg_q  <= cfg_i;
    end else if (at_last) begin
      busy_q <= 1'b0;
      slot_q <= '0;
    end else if (busy_q) begin
      slot_q <= slot_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign slot_o = slot_q;
  assign cfg_o  = cfg_q;

  p_slot_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ({1'b0, slot_q} <= last_slot));
endmodule

// File: rtl/ser_lane_mux.sv
module ser_lane_mux #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int POS_W    = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [POS_W-1:0]  idx_i,
  input  logic              narrow_i,
  input  logic              lsb_first_i,
  output logic              bit_o
);
  localparam logic [POS_W-1:0] SKIP    = POS_W'(WORD_W - NARROW_W);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(WORD_W - 1);

  logic [POS_W-1:0] pos;

  always_comb begin
    if (lsb_first_i) pos = narrow_i ? SKIP + idx_i : idx_i;
    else             pos = TOP_POS - idx_i;
    bit_o = word_i[pos];
  end
endmodule

// File: rtl/ser_strobe.sv
module ser_strobe #(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12,
  parameter int CNT_W    = 5
) (
  input  logic             busy_i,
  input  logic [CNT_W-1:0] slot_i,
  input  logic             single_lane_i,
  input  logic             narrow_i,
  input  logic             long_i,
  output logic             strobe_o
);
  localparam logic [CNT_W:0] FULL_N = (CNT_W+1)'(WORD_W);
  localparam logic [CNT_W:0] SHORT_N = (CNT_W+1)'(NARROW_W);

  logic [CNT_W:0] base_n, high_len;

  always_comb begin
    base_n   = narrow_i ? SHORT_N : FULL_N;
    high_len = single_lane_i ? base_n : (base_n >> 1);
    if (long_i) strobe_o = busy_i && ({1'b0, slot_i} < high_len);
    else        strobe_o = busy_i && (slot_i == '0);
  end
endmodule

// File: rtl/lvds_iq_serializer.sv
module lvds_iq_serializer
  import lvds_ser_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              single_lane_i,
  input  logic              narrow_i,
  input  logic              long_strobe_i,
  input  logic              lsb_first_i,
  input  logic              q_first_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] i_word_i,
  input  logic [WORD_W-1:0] q_word_i,
  output logic              lane_i_o,
  output logic              lane_q_o,
  output logic              strobe_o
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam int POS_W = $clog2(WORD_W);
  localparam int NUM_LANES = 2;
  localparam logic [CNT_W:0] FULL_N = (CNT_W+1)'(WORD_W);
  localparam logic [CNT_W:0] SHORT_N = (CNT_W+1)'(NARROW_W);

  ser_cfg_t         cfg_in, cfg_q;
  logic             load, busy;
  logic [CNT_W-1:0] slot;
  logic [WORD_W-1:0] i_q, q_q;

  assign cfg_in = '{single_lane: single_lane_i, narrow: narrow_i,
                    long_strobe: long_strobe_i, lsb_first: lsb_first_i,
                    q_first: q_first_i};

  ser_ctrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .cfg_i   (cfg_in),
    .ready_o (in_ready_o),
    .load_o  (load),
    .busy_o  (busy),
    .slot_o  (slot),
    .cfg_o   (cfg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_q <= '0;
      q_q <= '0;
    end else if (load) begin
      i_q <= i_word_i;
      q_q <= q_word_i;
    end
  end

  // single lane: slots past the first word index into the second word
  logic [CNT_W:0] base_n, slot_ext, idx0;
  logic           in_second;
  logic [WORD_W-1:0] lane_word [NUM_LANES];
  logic [POS_W-1:0]  lane_idx  [NUM_LANES];
  logic [NUM_LANES-1:0] lane_bit;

  always_comb begin
    base_n    = cfg_q.narrow ? SHORT_N : FULL_N;
    slot_ext  = {1'b0, slot};
    in_second = cfg_q.single_lane && (slot_ext >= base_n);
    idx0      = in_second ? slot_ext - base_n : slot_ext;
    lane_word[0] = (cfg_q.single_lane && (cfg_q.q_first ^ in_second)) ? q_q : i_q;
    lane_idx[0]  = POS_W'(idx0);
    lane_word[1] = q_q;
    lane_idx[1]  = POS_W'(slot_ext);
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    ser_lane_mux #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .POS_W(POS_W)) i_mux (
      .word_i      (lane_word[l]),
      .idx_i       (lane_idx[l]),
      .narrow_i    (cfg_q.narrow),
      .lsb_first_i (cfg_q.lsb_first),
      .bit_o       (lane_bit[l])
    );
  end

  ser_strobe #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .CNT_W(CNT_W)) i_strobe (
    .busy_i        (busy),
    .slot_i        (slot),
    .single_lane_i (cfg_q.single_lane),
    .narrow_i      (cfg_q.narrow),
    .long_i        (cfg_q.long_strobe),
    .strobe_o      (strobe_o)
  );

  assign lane_i_o = busy && lane_bit[0];
  assign lane_q_o = busy && !cfg_q.single_lane && lane_bit[1];

  p_strobe_after_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> strobe_o);

  p_strobe_rise_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(in_valid_i && in_ready_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o && !in_valid_i |=> !lane_i_o && !lane_q_o && !strobe_o);

  p_short_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o && !cfg_q.long_strobe |=> !strobe_o);

  p_single_q_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.single_lane |-> !lane_q_o);
endmodule

// File: tb/test_lvds_iq_serializer.sv
module test_lvds_iq_serializer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_lane, narrow, long_strobe, lsb_first, q_first;
  logic in_valid, in_ready;
  logic [15:0] i_word, q_word;
  logic lane_i, lane_q, strobe;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lvds_iq_serializer i_lvds_iq_serializer (
    .clk_i(clk), .rst_ni(rst_n),
    .single_lane_i(single_lane), .narrow_i(narrow), .long_strobe_i(long_strobe),
    .lsb_first_i(lsb_first), .q_first_i(q_first),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .i_word_i(i_word), .q_word_i(q_word),
    .lane_i_o(lane_i), .lane_q_o(lane_q), .strobe_o(strobe)
  );

  // {single, narrow, long, lsb_first, q_first, i[15:0], q[15:0]}
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {5'b00000, 16'hA5C3, 16'h3C5A},
    {5'b01000, 16'hF00F, 16'h0FF0},
    {5'b00100, 16'h1234, 16'hFEDC},
    {5'b01100, 16'h8001, 16'h7FFE},
    {5'b00010, 16'hC001, 16'h2468},
    {5'b01010, 16'h9AB0, 16'h5550},
    {5'b10000, 16'hB00B, 16'h0E0F},
    {5'b10001, 16'h1357, 16'hCAFE},
    {5'b11110, 16'hABC0, 16'h1230},
    {5'b10101, 16'hFFFF, 16'h0001}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int n_of(logic [36:0] v);
    return v[35] ? 12 : 16;
  endfunction

  function automatic int len_of(logic [36:0] v);
    return v[36] ? 2 * n_of(v) : n_of(v);
  endfunction

  function automatic logic pick(logic [15:0] w, int k, int n, logic lsb);
    return lsb ? w[16 - n + k] : w[15 - k];
  endfunction

  // expected {lane_i, lane_q, strobe} in slot s
  function automatic logic [2:0] exp_out(logic [36:0] v, int s);
    int n = n_of(v);
    logic [15:0] wi = v[31:16];
    logic [15:0] wq = v[15:0];
    logic st, b0, b1;
    if (v[36]) begin
      logic [15:0] w = ((s < n) ^ v[32]) ? wi : wq;
      b0 = pick(w, s % n, n, v[33]);
      b1 = 1'b0;
      st = v[34] ? (s < n) : (s == 0);
    end else begin
      b0 = pick(wi, s, n, v[33]);
      b1 = pick(wq, s, n, v[33]);
      st = v[34] ? (s < n / 2) : (s == 0);
    end
    return {b0, b1, st};
  endfunction

  task automatic drive(logic [36:0] v);
    {single_lane, narrow, long_strobe, lsb_first, q_first} = v[36:32];
    i_word = v[31:16];
    q_word = v[15:0];
  endtask

  task automatic check_slot(logic [36:0] v, int s);
    logic [2:0] e = exp_out(v, s);
    string dt = v[36] ? "R7 R5 R6" : "R4 R5 R6";
    string stg = !v[34] ? "R8" : (v[36] ? "R10" : "R9");
    chk(dt, {31'd0, lane_i}, {31'd0, e[2]});
    chk(v[36] ? "R7" : "R4", {31'd0, lane_q}, {31'd0, e[1]});
    chk(stg, {31'd0, strobe}, {31'd0, e[0]});
    chk("R2", {31'd0, in_ready}, {31'd0, s == len_of(v) - 1});
  endtask

  task automatic check_idle(string tag);
    chk(tag, {28'd0, lane_i, lane_q, strobe, in_ready}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    in_valid = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle");

    // back-to-back stream over all vectors (R3: no gap)
    drive(VEC[0]);
    in_valid = 1'b1;
    chk("R2 idle ready", {31'd0, in_ready}, 32'd1);
    for (int v = 0; v < NV; v++) begin
      for (int s = 0; s < len_of(VEC[v]); s++) begin
        @(negedge clk);
        if (s == 0) in_valid = 1'b0;
        check_slot(VEC[v], s);
        if (s == len_of(VEC[v]) - 1 && v < NV - 1) begin
          drive(VEC[v + 1]);
          in_valid = 1'b1;
        end
      end
    end
    @(negedge clk);
    check_idle("R1 after stream");
    @(negedge clk);
    check_idle("R1 stays idle");

    // R2: input changes after acceptance are ignored
    drive(VEC[3]);
    in_valid = 1'b1;
    for (int s = 0; s < len_of(VEC[3]); s++) begin
      @(negedge clk);
      if (s == 0) begin
        in_valid = 1'b0;
        drive(VEC[7]);
      end
      check_slot(VEC[3], s);
    end
    @(negedge clk);
    check_idle("R1 R2 after hold test");

    // R2: valid held high while busy does not restart the sample
    drive(VEC[6]);
    in_valid = 1'b1;
    for (int s = 0; s < len_of(VEC[6]); s++) begin
      @(negedge clk);
      if (s == len_of(VEC[6]) - 1) in_valid = 1'b0;
      check_slot(VEC[6], s);
    end
    @(negedge clk);
    check_idle("R1 R2 after held valid");

    // R1: asynchronous reset in mid-sample
    drive(VEC[9]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset release");

    finish_run();
  end
endmodule